// File: doc/BRIEF.md
# Shadowed Clock/Calendar Register Bank with Burst Sequencing

This block sits between a serial host front end, which has already turned the serial stream into decoded byte accesses, and a calendar counting core. It holds seven time and date bytes, a control byte whose top bit is a write-protect flag, a charger configuration byte, and a small scratch RAM. A transaction is framed by the `xfer_active` level. While it is high, the front end issues byte read and write strobes with an address and a clock-or-RAM select.

Reads of the time bytes come from a snapshot taken when the transaction opens. Reads therefore stay coherent while the core keeps counting. Writes to the time bytes go into a pending buffer. They are handed to the core as a single load pulse after the transaction closes.

Address 31 in either space selects burst mode. In burst mode, successive strobes walk an internal index upward from address 0. A clock burst write reaches the core only if all eight clock-space bytes (the seven time bytes and the control byte) were written. Write protection blocks every write except a single-byte write to the control byte.

Top module: `shadow_regbank`

## Requirements
- R1: After reset, `rd_data` is 0x00, `time_load` is 0, `chg_cfg` is 0x5C, `chg_en` is 0, and the control byte (clock address 7) reads 0x80, so write protect starts set.
- R2: The cycle in which `xfer_active` rises captures `live_time` (byte k in bits 8k+7..8k, clock address k for k = 0..6) into a snapshot. For the rest of the transaction, reads of clock addresses 0..6 return the snapshot, whatever `live_time` does.
- R3: A single-byte write to clock addresses 0..6 has no effect on `time_load` while the transaction is open. In the cycle after `xfer_active` falls, `time_load` pulses high for one cycle. `time_mask` bit k is set for each written address k, and the written value sits in lane k of `time_data`.
- R4: A clock burst write (`sel_ram`=0, address 31) commits only if at least eight bytes were written. The commit pulse then carries `time_mask`=0x7F with burst bytes 0..6 in lanes 0..6, and the control byte takes bit 7 of burst byte 7. If fewer than eight bytes were written, there is no pulse and the control byte is unchanged.
- R5: In a RAM burst (`sel_ram`=1, address 31), every byte written is stored at its burst index, even if the burst is shorter than the RAM. Single-byte RAM accesses use addresses 0..30.
- R6: Bit 7 of the control byte is write protect. While it is 1, writes to the time bytes, the charger byte and the RAM are dropped. A single-byte write to the control byte is always accepted. Bits 6..0 of the control byte always read 0.
- R7: If write protect is set when a clock burst write is issued, nothing commits, and that includes the control byte.
- R8: Clock addresses 9..30, and RAM burst positions past the last RAM byte, read 0x00 and ignore writes.
- R9: The charger byte is at clock address 8 and can be reached only by single-byte access. In a clock burst, index 8 reads 0x00. `chg_en` is 1 exactly when bits 7..4 are 1010 and bits 3..2 are 01 or 10.
- R10: The burst index is 0 at the start of every transaction and steps by one on each read or write strobe made in burst mode.
- R11: `rd_data` is registered. It presents the addressed byte in the cycle after `rd_stb` and holds its value in cycles with no read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_active | input | 1 | High for the duration of a host transaction |
| sel_ram | input | 1 | 0 selects clock space, 1 selects RAM space |
| addr | input | AW | Decoded byte address; all ones selects burst |
| wr_stb | input | 1 | Byte write strobe |
| wr_data | input | 8 | Write data |
| rd_stb | input | 1 | Byte read strobe |
| rd_data | output | 8 | Registered read data |
| live_time | input | 8*N_TIME | Running time bytes from the calendar core |
| time_load | output | 1 | One-cycle commit pulse toward the core |
| time_mask | output | N_TIME | Bytes to load on the commit pulse |
| time_data | output | 8*N_TIME | Byte lanes to load |
| chg_cfg | output | 8 | Charger configuration byte |
| chg_en | output | 1 | Charger enable decoded from the configuration |

## Verification
The assertions rely on three assumptions about the inputs:
- No strobe arrives in the first cycle of a transaction, nor while `xfer_active` is low.
- `wr_stb` and `rd_stb` are never high together.
- Each transaction carries a single command, so burst and single-byte accesses are not mixed.

The bench meets these assumptions by construction. Its transaction task raises `xfer_active` and waits one idle cycle before the first strobe. Every strobe lasts one cycle and is driven on a falling edge. Each transaction uses only one address kind.

// File: rtl/srb_pkg.sv
package srb_pkg;
   localparam int unsigned BYTE_W = 8;
   typedef logic [BYTE_W-1:0] byte_t;

   // charger enable: select nibble must be 1010 and diode field one-hot
   function automatic logic chg_decode(input byte_t cfg);
      return (cfg[7:4] == 4'b1010) && (cfg[3:2] == 2'b01 || cfg[3:2] == 2'b10);
   endfunction
endpackage

// File: rtl/srb_addr_seq.sv
module srb_addr_seq #(
   parameter int unsigned AW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          xfer_active,
   input  logic [AW-1:0] addr,
   input  logic          stb,
   output logic          is_burst,
   output logic [AW-1:0] eff_addr
);
   localparam logic [AW-1:0] CODE = '1;

   logic [AW-1:0] bidx_q;

   assign is_burst = (addr == CODE);
   assign eff_addr = is_burst ? bidx_q : addr;

   always_ff @(posedge clk) begin
      if (!rst_n)                                   bidx_q <= '0;
      else if (!xfer_active)                        bidx_q <= '0;
      else if (stb && is_burst && bidx_q != CODE)   bidx_q <= bidx_q + 1'b1;
   end

   p_burst_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_active && stb && is_burst && bidx_q != CODE) |=> (bidx_q == $past(bidx_q) + 1'b1));

   p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_active |=> (bidx_q == '0));
endmodule

// File: rtl/srb_time_shadow.sv
module srb_time_shadow #(
   parameter int unsigned N_TIME = 7,
   parameter int unsigned AW     = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic                  stop,
   input  logic [N_TIME*8-1:0]   live_time,
   input  logic                  wr_en,
   input  logic [AW-1:0]         wr_idx,
   input  logic [7:0]            wr_data,
   input  logic                  burst_wr,
   output logic [N_TIME*8-1:0]   snap,
   output logic                  time_load,
   output logic [N_TIME-1:0]     time_mask,
   output logic [N_TIME*8-1:0]   time_data,
   output logic                  ctrl_load,
   output logic                  ctrl_val
);
   localparam int unsigned CW = $clog2(N_TIME + 2);
   localparam logic [CW-1:0] FULL = CW'(N_TIME + 1);
   localparam logic [AW-1:0] TLIM = AW'(N_TIME);

   logic [N_TIME*8-1:0] pend_q;
   logic [N_TIME-1:0]   pmask_q;
   logic                pend_wp_q;
   logic                burst_q;
   logic [CW-1:0]       bcnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         snap <= '0; pend_q <= '0; pmask_q <= '0; pend_wp_q <= 1'b0;
         burst_q <= 1'b0; bcnt_q <= '0;
         time_load <= 1'b0; time_mask <= '0; time_data <= '0;
         ctrl_load <= 1'b0; ctrl_val <= 1'b0;
      end else begin
         time_load <= 1'b0;
         ctrl_load <= 1'b0;
         if (start) begin
            snap    <= live_time;
            pmask_q <= '0;
            burst_q <= 1'b0;
            bcnt_q  <= '0;
         end else if (wr_en) begin
            if (wr_idx < TLIM) begin
               pend_q[8*int'(wr_idx) +: 8] <= wr_data;
               pmask_q[wr_idx]             <= 1'b1;
            end else begin
               pend_wp_q <= wr_data[7];
            end
            if (burst_wr) begin
               burst_q <= 1'b1;
               if (bcnt_q != FULL) bcnt_q <= bcnt_q + 1'b1;
            end
         end
         if (stop) begin
            time_data <= pend_q;
            if (burst_q) begin
               time_load <= (bcnt_q == FULL);
               ctrl_load <= (bcnt_q == FULL);
               ctrl_val  <= pend_wp_q;
               time_mask <= '1;
            end else begin
               time_load <= |pmask_q;
               time_mask <= pmask_q;
            end
         end
      end
   end

   p_snap_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> $stable(snap));

   p_load_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      time_load |=> !time_load);

   p_burst_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (time_load && burst_q) |-> (&time_mask));
endmodule

// File: rtl/srb_scratch.sv
module srb_scratch #(
   parameter int unsigned DEPTH     = 31,
   parameter int unsigned AW        = 5,
   parameter bit          RESET_EN  = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);
   localparam logic [AW-1:0] LIM = AW'(DEPTH);

   logic [7:0] mem [DEPTH];

   generate
      if (RESET_EN) begin : g_rst
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
            end else if (we) begin
               mem[waddr] <= wdata;
            end
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (we) mem[waddr] <= wdata;
         end
      end
   endgenerate

   assign rdata = (raddr < LIM) ? mem[raddr] : 8'h00;

   p_ram_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (waddr < LIM));
endmodule

// File: rtl/shadow_regbank.sv
module shadow_regbank
   import srb_pkg::*;
#(
   parameter int unsigned N_TIME    = 7,
   parameter int unsigned RAM_DEPTH = 31,
   parameter int unsigned AW        = 5,
   parameter bit          RAM_RESET = 1'b1,
   parameter logic [7:0]  CHG_RESET = 8'h5C,
   parameter bit          WP_RESET  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                xfer_active,
   input  logic                sel_ram,
   input  logic [AW-1:0]       addr,
   input  logic                wr_stb,
   input  logic [7:0]          wr_data,
   input  logic                rd_stb,
   output logic [7:0]          rd_data,
   input  logic [N_TIME*8-1:0] live_time,
   output logic                time_load,
   output logic [N_TIME-1:0]   time_mask,
   output logic [N_TIME*8-1:0] time_data,
   output logic [7:0]          chg_cfg,
   output logic                chg_en
);
   localparam logic [AW-1:0] CTRL_A = AW'(N_TIME);
   localparam logic [AW-1:0] CHG_A  = AW'(N_TIME + 1);
   localparam logic [AW-1:0] TLIM   = AW'(N_TIME);
   localparam logic [AW-1:0] RLIM   = AW'(RAM_DEPTH);
   localparam int unsigned   TIW    = $clog2(N_TIME);

   generate
      if (N_TIME + 2 > (2 ** AW) - 1) begin : g_bad_time
         $error("clock space does not fit below the burst code");
      end
      if (RAM_DEPTH > (2 ** AW) - 1) begin : g_bad_ram
         $error("RAM depth collides with the burst code");
      end
   endgenerate

   logic          xfer_q, start, stop;
   logic          is_burst;
   logic [AW-1:0] eff_addr;
   logic          hit_time, hit_ctrl, hit_chg, hit_ram;
   logic          wp_q;
   logic [7:0]    chg_q, rd_q, rd_mux, ram_rdata;
   logic          sh_wr_en, ram_we, ctrl_load, ctrl_val;
   logic [N_TIME*8-1:0] snap;

   assign start = xfer_active & ~xfer_q;
   assign stop  = ~xfer_active & xfer_q;

   srb_addr_seq #(.AW(AW)) u_seq (
      .clk(clk), .rst_n(rst_n), .xfer_active(xfer_active), .addr(addr),
      .stb(wr_stb | rd_stb), .is_burst(is_burst), .eff_addr(eff_addr));

   always_comb begin
      hit_time = !sel_ram && (eff_addr < TLIM);
      hit_ctrl = !sel_ram && (eff_addr == CTRL_A);
      hit_chg  = !sel_ram && !is_burst && (eff_addr == CHG_A);
      hit_ram  = sel_ram && (eff_addr < RLIM);
      sh_wr_en = wr_stb && !wp_q && (hit_time || (is_burst && hit_ctrl));
      ram_we   = wr_stb && !wp_q && hit_ram;
      if (hit_time)      rd_mux = snap[8*int'(eff_addr[TIW-1:0]) +: 8];
      else if (hit_ctrl) rd_mux = {wp_q, 7'b0};
      else if (hit_chg)  rd_mux = chg_q;
      else if (hit_ram)  rd_mux = ram_rdata;
      else               rd_mux = 8'h00;
   end

   srb_time_shadow #(.N_TIME(N_TIME), .AW(AW)) u_shadow (
      .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
      .live_time(live_time), .wr_en(sh_wr_en), .wr_idx(eff_addr),
      .wr_data(wr_data), .burst_wr(is_burst && !sel_ram), .snap(snap),
      .time_load(time_load), .time_mask(time_mask), .time_data(time_data),
      .ctrl_load(ctrl_load), .ctrl_val(ctrl_val));

   srb_scratch #(.DEPTH(RAM_DEPTH), .AW(AW), .RESET_EN(RAM_RESET)) u_ram (
      .clk(clk), .rst_n(rst_n), .we(ram_we), .waddr(eff_addr),
      .wdata(wr_data), .raddr(eff_addr), .rdata(ram_rdata));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         xfer_q <= 1'b0;
         wp_q   <= WP_RESET;
         chg_q  <= CHG_RESET;
         rd_q   <= 8'h00;
      end else begin
         xfer_q <= xfer_active;
         if (ctrl_load)                              wp_q <= ctrl_val;
         else if (wr_stb && hit_ctrl && !is_burst)   wp_q <= wr_data[7];
         if (wr_stb && hit_chg && !wp_q)             chg_q <= wr_data;
         if (rd_stb)                                 rd_q <= rd_mux;
      end
   end

   assign rd_data = rd_q;
   assign chg_cfg = chg_q;
   assign chg_en  = chg_decode(chg_q);

   p_ctrl_low_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && hit_ctrl) |=> (rd_data[6:0] == 7'b0));

   p_wp_chg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wp_q && wr_stb) |=> $stable(chg_cfg));

   p_chg_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
      chg_en |-> (chg_cfg[7:4] == 4'hA && (chg_cfg[3] ^ chg_cfg[2])));

   p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |=> $stable(rd_data));
endmodule

// File: tb/shadow_regbank_bench.sv
module shadow_regbank_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        xfer_active = 1'b0, sel_ram = 1'b0, wr_stb = 1'b0, rd_stb = 1'b0;
   logic [4:0]  addr = '0;
   logic [7:0]  wr_data = '0;
   logic [7:0]  rd_data;
   logic [55:0] live_time = '0;
   logic        time_load, chg_en;
   logic [6:0]  time_mask;
   logic [55:0] time_data;
   logic [7:0]  chg_cfg;

   int checks = 0, errors = 0;
   logic        ld, ld2;
   logic [6:0]  mk;
   logic [55:0] dt;
   logic [7:0]  v;

   always #4 clk = ~clk;

   shadow_regbank u_shadow_regbank (
      .clk(clk), .rst_n(rst_n), .xfer_active(xfer_active), .sel_ram(sel_ram),
      .addr(addr), .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb),
      .rd_data(rd_data), .live_time(live_time), .time_load(time_load),
      .time_mask(time_mask), .time_data(time_data), .chg_cfg(chg_cfg),
      .chg_en(chg_en));

   // {write value, expected enable}
   localparam logic [8:0] CHG_VEC [8] = '{
      {8'hA5, 1'b1}, {8'hA9, 1'b1}, {8'hAD, 1'b0}, {8'hA1, 1'b0},
      {8'h55, 1'b0}, {8'hA4, 1'b1}, {8'hB5, 1'b0}, {8'hAA, 1'b1}};

   task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
      end
   endtask

   task automatic wr(input logic s, input logic [4:0] a, input logic [7:0] d);
      @(negedge clk); sel_ram = s; addr = a; wr_data = d; wr_stb = 1'b1;
      @(negedge clk); wr_stb = 1'b0;
   endtask

   task automatic rd(input logic s, input logic [4:0] a, output logic [7:0] q);
      @(negedge clk); sel_ram = s; addr = a; rd_stb = 1'b1;
      @(negedge clk); rd_stb = 1'b0; q = rd_data;
   endtask

   task automatic xbeg();
      @(negedge clk); xfer_active = 1'b1;
      @(negedge clk);
   endtask

   task automatic xend();
      @(negedge clk); xfer_active = 1'b0;
      @(negedge clk); ld = time_load; mk = time_mask; dt = time_data;
      @(negedge clk); ld2 = time_load;
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(8 * 200000);
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 rd_data", rd_data, 8'h00);
      chk("R1 time_load", time_load, 1'b0);
      chk("R1 chg_cfg", chg_cfg, 8'h5C);
      chk("R1 chg_en", chg_en, 1'b0);

      // R6 protected writes dropped
      xbeg();
      rd(1'b0, 5'd7, v); chk("R1 ctrl reset", v, 8'h80);
      wr(1'b1, 5'd2, 8'h11);
      wr(1'b0, 5'd0, 8'h33);
      wr(1'b0, 5'd8, 8'hA5);
      chk("R6 charger blocked", chg_cfg, 8'h5C);
      rd(1'b1, 5'd2, v); chk("R6 ram blocked", v, 8'h00);
      xend();
      chk("R6 time blocked", ld, 1'b0);

      // R6 control accepted, low bits read zero; R9 charger table
      xbeg();
      wr(1'b0, 5'd7, 8'h7F);
      rd(1'b0, 5'd7, v); chk("R6 ctrl low bits", v, 8'h00);
      for (int i = 0; i < 8; i++) begin
         wr(1'b0, 5'd8, CHG_VEC[i][8:1]);
         chk("R9 chg_cfg", chg_cfg, CHG_VEC[i][8:1]);
         chk("R9 chg_en", chg_en, CHG_VEC[i][0]);
      end
      xend();

      // R2 snapshot
      live_time = 56'h21_07_15_12_09_30_45;
      xbeg();
      live_time = 56'h22_01_16_13_10_31_46;
      rd(1'b0, 5'd0, v); chk("R2 snap lane0", v, 8'h45);
      rd(1'b0, 5'd6, v); chk("R2 snap lane6", v, 8'h21);
      xend();
      xbeg();
      rd(1'b0, 5'd0, v); chk("R2 new snapshot", v, 8'h46);
      xend();

      // R3 deferred single writes
      xbeg();
      wr(1'b0, 5'd2, 8'h45);
      wr(1'b0, 5'd4, 8'h12);
      chk("R3 no load mid", time_load, 1'b0);
      xend();
      chk("R3 load", ld, 1'b1);
      chk("R3 mask", mk, 7'b0010100);
      chk("R3 lane2", dt[23:16], 8'h45);
      chk("R3 lane4", dt[39:32], 8'h12);
      chk("R3 one cycle", ld2, 1'b0);

      // R4 partial burst
      xbeg();
      for (int i = 0; i < 5; i++) wr(1'b0, 5'd31, 8'(8'h10 + i));
      xend();
      chk("R4 partial no load", ld, 1'b0);
      xbeg(); rd(1'b0, 5'd7, v); chk("R4 ctrl unchanged", v, 8'h00); xend();

      // R4 full burst
      xbeg();
      for (int i = 0; i < 8; i++) wr(1'b0, 5'd31, (i == 7) ? 8'h80 : 8'(8'h50 + i));
      xend();
      chk("R4 full load", ld, 1'b1);
      chk("R4 mask", mk, 7'h7F);
      chk("R4 data", dt, 56'h56_55_54_53_52_51_50);
      xbeg(); rd(1'b0, 5'd7, v); chk("R4 ctrl from burst", v, 8'h80); xend();

      // R7 burst under protect
      xbeg();
      for (int i = 0; i < 8; i++) wr(1'b0, 5'd31, (i == 7) ? 8'h00 : 8'(8'h60 + i));
      xend();
      chk("R7 no load", ld, 1'b0);
      xbeg();
      rd(1'b0, 5'd7, v); chk("R7 ctrl kept", v, 8'h80);
      wr(1'b0, 5'd7, 8'h00);
      xend();

      // R8 empty clock addresses, R9 charger not in burst, R10 index from 0
      xbeg();
      wr(1'b0, 5'd12, 8'hFF);
      rd(1'b0, 5'd12, v); chk("R8 empty clock addr", v, 8'h00);
      for (int i = 0; i < 10; i++) begin
         rd(1'b0, 5'd31, v);
         if (i < 7) chk("R10 clock burst read", v, live_time[8*i +: 8]);
         else       chk("R9 burst idx 7..9", v, 8'h00);
      end
      xend();

      // R5 RAM burst, R8 past end
      xbeg();
      for (int i = 0; i < 32; i++) wr(1'b1, 5'd31, (i == 31) ? 8'hEE : 8'(i + 1));
      xend();
      xbeg();
      for (int i = 0; i < 32; i++) begin
         rd(1'b1, 5'd31, v);
         if (i < 31) chk("R5 ram burst", v, 8'(i + 1));
         else        chk("R8 ram past end", v, 8'h00);
      end
      xend();
      xbeg();
      rd(1'b1, 5'd4, v); chk("R5 ram single", v, 8'h05);
      @(negedge clk); chk("R11 rd hold", rd_data, 8'h05);
      xend();

      finish_run();
   end
endmodule